// File: doc/BRIEF.md
# Eight-Bit Logic and Arithmetic Unit with Signed Compare

This unit performs one operation per clock on two 8-bit operands, the source operand and the destination operand, selected by a 4-bit opcode. The logic operations share one set of propagate (OR) and generate (AND) terms with the carry-lookahead adder. The exclusive-OR is formed from those two terms rather than from a separate gate. A copy path returns the source operand unchanged.

Subtraction and both compares add the inverted destination operand with a forced carry-in of one. The signed compare reuses the unsigned carry and inverts it when the two sign bits differ. Results, the carry flag and a no-write indication are registered, so each output appears one clock after its inputs are sampled. Register file, flag storage and instruction decode from the instruction word are outside the block.

Top module: `rop2_alu`

## Requirements
- R1: While `rst_n` is low, `result_o`, `carry_o` and `no_write_o` are all zero.
- R2: Opcodes 0000, 0001 and 0010 give `sri_i & snd_i`, `sri_i | snd_i` and `sri_i ^ snd_i` on `result_o`.
- R3: Opcode 0011 gives `sri_i & ~snd_i` on `result_o`.
- R4: Opcode 0111 gives the low 8 bits of `sri_i + snd_i + carry_i` on `result_o` and bit 8 of that sum on `carry_o`.
- R5: Opcode 0110 gives `(sri_i - snd_i) mod 256` on `result_o`. It sets `carry_o` to 1 exactly when `sri_i >= snd_i` unsigned, and `carry_i` has no effect.
- R6: Opcode 0100 sets `carry_o` to 1 exactly when `sri_i >= snd_i` unsigned. It drives `result_o` with `(sri_i - snd_i) mod 256`, asserts `no_write_o`, and `carry_i` has no effect.
- R7: Opcode 0101 sets `carry_o` to 1 exactly when `sri_i >= snd_i` as two's-complement numbers. It drives `result_o` with `(sri_i - snd_i) mod 256` and asserts `no_write_o`.
- R8: Any opcode with bit 3 set gives `sri_i` unchanged on `result_o`, whatever `snd_i` is.
- R9: Opcodes 0000 to 0011 and any opcode with bit 3 set drive `carry_o` to 0. All opcodes other than 0100 and 0101 drive `no_write_o` to 0.
- R10: Each output holds until the next rising clock edge and then reflects the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| sri_i | input | 8 | Source operand |
| snd_i | input | 8 | Destination operand, second input |
| carry_i | input | 1 | Carry-in for addition |
| result_o | output | 8 | Registered result |
| carry_o | output | 1 | Registered carry / compare flag |
| no_write_o | output | 1 | Registered indication that the result must not be written back |

## Verification
The assertions in the top module run on every cycle. They check that the copy path returns the source, that compares raise the no-write indication, that logic operations clear the carry, and that addition and both compares agree with arithmetic on the operands sampled one clock earlier. Only the bench scenarios can show that `carry_i` has no effect on subtraction, that every sign combination is handled by the signed-compare correction, that the exclusive-OR derived from the propagate and generate terms is exact, and that outputs hold steady between edges.

// File: rtl/rop2_alu_pkg.sv
`timescale 1ns/1ps
package rop2_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND  = 4'b0000,
        OP_OR   = 4'b0001,
        OP_XOR  = 4'b0010,
        OP_ANDN = 4'b0011,
        OP_CMPU = 4'b0100,
        OP_CMPS = 4'b0101,
        OP_SUB  = 4'b0110,
        OP_ADD  = 4'b0111,
        OP_SET  = 4'b1000
    } alu_op_e;

    typedef struct packed {
        logic pass;       // copy source through the AND path
        logic neg;        // invert second operand
        logic or_sel;     // 1: OR term, 0: XOR term
        logic rop_sel;    // 1: OR/XOR branch, 0: AND branch
        logic arith_sel;  // 1: adder sum, 0: logic result
        logic force_cin;  // carry-in forced to one
        logic signed_cmp; // apply sign-bit carry correction
        logic no_write;   // result is not to be written back
    } alu_ctrl_t;

endpackage

// File: rtl/rop2_alu_decode.sv
`timescale 1ns/1ps
module rop2_alu_decode
    import rop2_alu_pkg::*;
(
    input  logic [3:0] op,
    output alu_ctrl_t  ctrl
);
    logic f0, f1, f2, f3;

    always_comb begin
        {f3, f2, f1, f0} = op;
        ctrl.pass       = f3;
        ctrl.neg        = ~f3 & ((f0 & f1) ^ f2);
        ctrl.or_sel     = ~(f1 | f2 | f3);
        ctrl.rop_sel    = ~f3 & (f0 ^ f1);
        ctrl.arith_sel  = ~f3 & f2;
        ctrl.force_cin  = ~f3 & f2 & ~(f0 & f1);
        ctrl.signed_cmp = ~f3 & f2 & ~f1 & f0;
        ctrl.no_write   = ~f3 & f2 & ~f1;
    end
endmodule

// File: rtl/rop2_alu_logic.sv
`timescale 1ns/1ps
module rop2_alu_logic
    import rop2_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] sri,
    input  logic [W-1:0] snd,
    input  alu_ctrl_t    ctrl,
    output logic [W-1:0] prop,
    output logic [W-1:0] gen,
    output logic [W-1:0] xsum,
    output logic [W-1:0] logic_res
);
    logic [W-1:0] snd_eff;
    logic [W-1:0] gen_pass;
    logic [W-1:0] orx;

    always_comb begin
        snd_eff   = snd ^ {W{ctrl.neg}};
        prop      = sri | snd_eff;
        gen       = sri & snd_eff;
        xsum      = prop & ~gen;
        gen_pass  = gen | (sri & {W{ctrl.pass}});
        orx       = ctrl.or_sel ? prop : xsum;
        logic_res = ctrl.rop_sel ? orx : gen_pass;
    end
endmodule

// File: rtl/rop2_alu_cla.sv
`timescale 1ns/1ps
module rop2_alu_cla #(
    parameter int W   = 8,
    parameter int GRP = 3
) (
    input  logic [W-1:0] prop,
    input  logic [W-1:0] gen,
    input  logic [W-1:0] xsum,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int NGRP = (W + GRP - 1) / GRP;

    logic [NGRP:0] grp_c;
    logic [W-1:0]  bit_c;

    assign grp_c[0] = cin;

    for (genvar j = 0; j < NGRP; j++) begin : g_grp
        localparam int LO = j * GRP;
        localparam int HI = ((LO + GRP) > W) ? (W - 1) : (LO + GRP - 1);
        logic gg, gp;

        always_comb begin
            gg = 1'b0;
            gp = 1'b1;
            for (int i = LO; i <= HI; i++) begin
                gg = gen[i] | (prop[i] & gg);
                gp = gp & prop[i];
            end
        end

        assign grp_c[j+1] = gg | (gp & grp_c[j]);
        assign bit_c[LO]  = grp_c[j];

        for (genvar i = LO; i < HI; i++) begin : g_bit
            assign bit_c[i+1] = gen[i] | (prop[i] & bit_c[i]);
        end
    end

    assign sum  = xsum ^ bit_c;
    assign cout = grp_c[NGRP];
endmodule

// File: rtl/rop2_alu.sv
`timescale 1ns/1ps
module rop2_alu
    import rop2_alu_pkg::*;
#(
    parameter int W   = 8,
    parameter int GRP = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] sri_i,
    input  logic [W-1:0] snd_i,
    input  logic         carry_i,
    output logic [W-1:0] result_o,
    output logic         carry_o,
    output logic         no_write_o
);
    alu_ctrl_t    ctrl;
    logic [W-1:0] prop, gen, xsum, logic_res, sum;
    logic         cin_eff, cout, carry_d;
    logic [W-1:0] result_d;

    rop2_alu_decode u_dec (
        .op   (op_i),
        .ctrl (ctrl)
    );

    rop2_alu_logic #(.W(W)) u_logic (
        .sri       (sri_i),
        .snd       (snd_i),
        .ctrl      (ctrl),
        .prop      (prop),
        .gen       (gen),
        .xsum      (xsum),
        .logic_res (logic_res)
    );

    assign cin_eff = ctrl.force_cin | carry_i;

    rop2_alu_cla #(.W(W), .GRP(GRP)) u_cla (
        .prop (prop),
        .gen  (gen),
        .xsum (xsum),
        .cin  (cin_eff),
        .sum  (sum),
        .cout (cout)
    );

    // With the second operand inverted, a zero XOR term at the top bit
    // means the original sign bits differ.
    always_comb begin
        result_d = ctrl.arith_sel ? sum : logic_res;
        carry_d  = ctrl.arith_sel & (cout ^ (ctrl.signed_cmp & ~xsum[W-1]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o   <= '0;
            carry_o    <= 1'b0;
            no_write_o <= 1'b0;
        end else begin
            result_o   <= result_d;
            carry_o    <= carry_d;
            no_write_o <= ctrl.no_write;
        end
    end

    p_set_copies_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i[3])) |-> (result_o == $past(sri_i)));

    p_cmp_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i) == OP_CMPU || $past(op_i) == OP_CMPS))
        |-> no_write_o);

    p_logic_carry_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i[3]) || $past(op_i[3:2]) == 2'b00))
        |-> (!carry_o && !no_write_o));

    p_add_total_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_ADD)
        |-> ({carry_o, result_o} ==
             ({1'b0, $past(sri_i)} + {1'b0, $past(snd_i)} + {{W{1'b0}}, $past(carry_i)})));

    p_cmpu_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_CMPU)
        |-> (carry_o == ($past(sri_i) >= $past(snd_i))));

    p_cmps_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_CMPS)
        |-> (carry_o == ($signed($past(sri_i)) >= $signed($past(snd_i)))));

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> (result_o == '0 && !carry_o && !no_write_o));
endmodule

// File: tb/test_rop2_alu.sv
`timescale 1ns/1ps
module test_rop2_alu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] a = 8'd0, b = 8'd0;
    logic       cin = 1'b0;
    logic [7:0] result;
    logic       carry, no_write;

    int n_checks = 0;
    int n_fail   = 0;
    logic [9:0] exp_now = 10'd0;

    always #2.5 clk = ~clk;

    rop2_alu i_rop2_alu (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op),
        .sri_i      (a),
        .snd_i      (b),
        .carry_i    (cin),
        .result_o   (result),
        .carry_o    (carry),
        .no_write_o (no_write)
    );

    function automatic logic [9:0] model(input logic [3:0] o, input logic [7:0] x,
                                         input logic [7:0] y, input logic c);
        int ux = x, uy = y;
        int sx = $signed(x), sy = $signed(y);
        int tot;
        logic [7:0] r = 8'd0;
        logic cf = 1'b0, nw = 1'b0;
        if (o[3]) r = x;
        else case (o[2:0])
            3'd0: r = x & y;
            3'd1: r = x | y;
            3'd2: r = x ^ y;
            3'd3: r = x & ~y;
            3'd4: begin r = 8'(ux - uy); cf = (ux >= uy); nw = 1'b1; end
            3'd5: begin r = 8'(ux - uy); cf = (sx >= sy); nw = 1'b1; end
            3'd6: begin r = 8'(ux - uy); cf = (ux >= uy); end
            default: begin tot = ux + uy + int'(c); r = 8'(tot); cf = tot[8]; end
        endcase
        return {nw, cf, r};
    endfunction

    function automatic string tag(input logic [3:0] o);
        if (o[3]) return "R8";
        case (o[2:0])
            3'd0, 3'd1, 3'd2: return "R2";
            3'd3: return "R3";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got nw/c/res=%b/%b/%h expected %b/%b/%h",
                     req, got[9], got[8], got[7:0], exp[9], exp[8], exp[7:0]);
        end
    endtask

    // Drive on the falling edge, confirm the outputs are still the old
    // values (R10), then compare one falling edge later.
    task automatic run(input logic [3:0] o, input logic [7:0] x,
                       input logic [7:0] y, input logic c);
        logic [9:0] e;
        op = o; a = x; b = y; cin = c;
        e = model(o, x, y, c);
        #1;
        check("R10", {no_write, carry, result}, exp_now);
        @(posedge clk);
        @(negedge clk);
        check(tag(o), {no_write, carry, result}, e);
        if (o[3] || o[2:0] < 3'd4)
            check("R9", {no_write, carry}, 2'b00);
        exp_now = e;
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] signs [4] = '{8'h05, 8'h85, 8'h7F, 8'h80};
        logic [9:0] first;
        op = 4'b0111; a = 8'hFF; b = 8'hFF; cin = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", {no_write, carry, result}, 10'd0);
        rst_n = 1'b1;
        @(negedge clk);
        exp_now = model(op, a, b, cin);
        check("R10", {no_write, carry, result}, exp_now);

        run(4'b0000, 8'hF0, 8'h3C, 1'b1);
        run(4'b0001, 8'hF0, 8'h3C, 1'b0);
        run(4'b0010, 8'hF0, 8'h3C, 1'b0);
        run(4'b0011, 8'hF0, 8'h3C, 1'b1);
        run(4'b0111, 8'hFF, 8'h01, 1'b0);
        run(4'b0111, 8'hFF, 8'h00, 1'b1);
        run(4'b0110, 8'h10, 8'h10, 1'b0);
        run(4'b0110, 8'h0F, 8'h10, 1'b1);
        // R5 carry-in must not matter: same operands, both carry-in values
        run(4'b0110, 8'h40, 8'h3F, 1'b0);
        first = exp_now;
        run(4'b0110, 8'h40, 8'h3F, 1'b1);
        check("R5", exp_now, first);
        run(4'b0100, 8'h00, 8'hFF, 1'b1);
        run(4'b0101, 8'h80, 8'h7F, 1'b0);
        run(4'b0101, 8'h7F, 8'h80, 1'b1);
        run(4'b1000, 8'hA5, 8'h00, 1'b1);
        run(4'b1111, 8'h5A, 8'hFF, 1'b0);

        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                for (int o = 4; o < 7; o++)
                    run(4'(o), signs[i], signs[j], 1'(j));

        for (int k = 0; k < 600; k++)
            run(4'($urandom_range(0, 9) == 9 ? 4'b1000 + 4'($urandom_range(0, 7))
                                             : $urandom_range(0, 7)),
                8'($urandom), 8'($urandom), 1'($urandom));

        rst_n = 1'b0;
        #1;
        check("R1", {no_write, carry, result}, 10'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule